// File: doc/BRIEF.md
# Sequential Block Chain Controller

This controller sits between one upstream four-phase request/acknowledge pair and a fixed number of child blocks, each reached through its own four-phase pair. When upstream asks for work, the controller starts the first block, waits for that block's acknowledge, starts the next one, and so on down the chain. After the final block acknowledges, the controller acknowledges upstream. A child block may be a plain dataflow unit or a conditional or loop unit. Such a unit decides for itself, from its own condition flag, whether its inner body runs. To the chain it is just one more request/acknowledge pair.

Once started, every block request stays high until upstream withdraws its request. All block requests then drop together. The upstream acknowledge stays high until every block acknowledge has returned to zero, so the whole tree is back at rest before upstream may begin another cycle. The controller is a clocked state machine with registered outputs. A separate monitor raises a one-cycle error pulse when any block acknowledge moves away from its request level.

Top module: `blk_chain_seq`

## Requirements
- R1: During and right after reset every block request, the upstream acknowledge and the error output are low.
- R2: With every block acknowledge low, a high upstream request raises block request 0 (bit 0 of `blk_req`) at the next clock edge. No other block request rises with it. While the upstream request is low, no block request rises.
- R3: Block request k+1 rises at the clock edge after block acknowledge k is seen high, and never earlier. Requests rise strictly in index order 0, 1, 2.
- R4: The upstream acknowledge rises at the clock edge after the last block's acknowledge is seen high. At that point all block requests are still high, and they stay high while the upstream request stays high.
- R5: At the clock edge after the upstream request is seen low while the upstream acknowledge is high, all block requests fall together. The upstream acknowledge stays high.
- R6: The upstream acknowledge falls at the clock edge after every block acknowledge is seen low, in whatever order they fell. It stays high while any of them is high.
- R7: A block request does not rise while that block's acknowledge is still high. Both the chain start and each hop wait until that acknowledge has fallen.
- R8: `proto_err` is high for exactly one cycle after a clock edge that samples a block acknowledge changing to the opposite level of its block request. This covers a rise while the request is low and a fall while the request is high. Changes that follow the request do not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_req | input | 1 | Upstream request |
| up_ack | output | 1 | Upstream acknowledge |
| blk_req | output | NBLK | Request to each child block, bit k for block k |
| blk_ack | input | NBLK | Acknowledge from each child block |
| proto_err | output | 1 | One-cycle pulse on a handshake violation by a child block |

## Verification
Every output is registered, so each result is due exactly one clock edge after the input change that causes it. This holds for each hop along the chain, for the upstream acknowledge in both directions, for the collective request drop and for the error pulse. The bench drives inputs on the falling edge and samples one falling edge later. Where a result must not come yet, it samples again after further edges with the triggering input still held back. In the error case, it samples the following cycle as well, to confirm the pulse lasts one cycle.

// File: rtl/blk_chain_pkg.sv
package blk_chain_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_HOLD  = 2'd2,
        ST_DRAIN = 2'd3
    } chain_state_e;

endpackage

// File: rtl/blk_chain_fsm.sv
module blk_chain_fsm
    import blk_chain_pkg::*;
#(
    parameter int NBLK = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            up_req,
    input  logic [NBLK-1:0] blk_ack,
    output logic            up_ack,
    output logic [NBLK-1:0] blk_req
);

    localparam int IW = (NBLK > 1) ? $clog2(NBLK) : 1;
    localparam logic [IW-1:0] LAST = IW'(NBLK - 1);

    typedef struct packed {
        chain_state_e    st;
        logic [IW-1:0]   idx;
        logic [NBLK-1:0] req;
        logic            ack;
    } fsm_t;

    fsm_t q, d;
    logic [IW-1:0] nxt;

    assign nxt = q.idx + 1'b1;

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (up_req && (blk_ack == '0)) begin
                    d.req    = '0;
                    d.req[0] = 1'b1;
                    d.idx    = '0;
                    d.st     = ST_RUN;
                end
            end
            ST_RUN: begin
                if (blk_ack[q.idx]) begin
                    if (q.idx == LAST) begin
                        d.ack = 1'b1;
                        d.st  = ST_HOLD;
                    end else if (!blk_ack[nxt]) begin
                        d.req[nxt] = 1'b1;
                        d.idx      = nxt;
                    end
                end
            end
            ST_HOLD: begin
                if (!up_req) begin
                    d.req = '0;
                    d.st  = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (blk_ack == '0) begin
                    d.ack = 1'b0;
                    d.st  = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= ST_IDLE;
            q.idx <= '0;
            q.req <= '0;
            q.ack <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign up_ack  = q.ack;
    assign blk_req = q.req;

endmodule

// File: rtl/blk_chain_errmon.sv
module blk_chain_errmon #(
    parameter int NBLK = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NBLK-1:0] blk_req,
    input  logic [NBLK-1:0] blk_ack,
    output logic            proto_err
);

    typedef struct packed {
        logic [NBLK-1:0] ack_prev;
        logic            err;
    } mon_t;

    mon_t q, d;
    logic [NBLK-1:0] lane_bad;

    for (genvar k = 0; k < NBLK; k++) begin : g_lane
        // a move of the acknowledge is legal only toward its request level
        assign lane_bad[k] = (blk_ack[k] != q.ack_prev[k]) && (blk_ack[k] != blk_req[k]);
    end

    always_comb begin
        d          = q;
        d.ack_prev = blk_ack;
        d.err      = |lane_bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ack_prev <= '0;
            q.err      <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign proto_err = q.err;

endmodule

// File: rtl/blk_chain_seq.sv
module blk_chain_seq #(
    parameter int NBLK = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            up_req,
    output logic            up_ack,
    output logic [NBLK-1:0] blk_req,
    input  logic [NBLK-1:0] blk_ack,
    output logic            proto_err
);

    logic [NBLK-1:0] req_w;

    blk_chain_fsm #(.NBLK(NBLK)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .up_req  (up_req),
        .blk_ack (blk_ack),
        .up_ack  (up_ack),
        .blk_req (req_w)
    );

    blk_chain_errmon #(.NBLK(NBLK)) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk_req   (req_w),
        .blk_ack   (blk_ack),
        .proto_err (proto_err)
    );

    assign blk_req = req_w;

endmodule

// File: rtl/blk_chain_seq_chk.sv
module blk_chain_seq_chk #(
    parameter int NBLK = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            up_req,
    input logic            up_ack,
    input logic [NBLK-1:0] blk_req,
    input logic [NBLK-1:0] blk_ack,
    input logic            proto_err
);

    // R2: the first block starts only on a seen upstream request
    a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blk_req[0]) |-> $past(up_req));

    for (genvar k = 1; k < NBLK; k++) begin : g_order
        // R3: each later block waits for its predecessor's acknowledge
        a_r3_order: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(blk_req[k]) |-> ($past(blk_ack[k-1]) && $past(blk_req[k-1])));
    end

    for (genvar k = 0; k < NBLK; k++) begin : g_stale
        // R7: no new request while the old acknowledge is still high
        a_r7_stale: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(blk_req[k]) |-> !$past(blk_ack[k]));
    end

    // R4: upstream completion follows the last block with every request held
    a_r4_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up_ack) |-> ($past(blk_ack[NBLK-1]) && (&blk_req)));

    // R5: requests drop all at once, only after upstream withdrew, with acknowledge held
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(|blk_req) |-> ((blk_req == '0) && up_ack && !$past(up_req)));

    // R6: upstream acknowledge falls only once every child is back at zero
    a_r6_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(up_ack) |-> ($past(blk_ack) == '0));

endmodule

bind blk_chain_seq blk_chain_seq_chk #(.NBLK(NBLK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .up_req    (up_req),
    .up_ack    (up_ack),
    .blk_req   (blk_req),
    .blk_ack   (blk_ack),
    .proto_err (proto_err)
);

// File: tb/blk_chain_seq_test.sv
module blk_chain_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          up_req;
    logic          up_ack;
    logic [NB-1:0] blk_req;
    logic [NB-1:0] blk_ack;
    logic          proto_err;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blk_chain_seq #(.NBLK(NB)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .up_req    (up_req),
        .up_ack    (up_ack),
        .blk_req   (blk_req),
        .blk_ack   (blk_ack),
        .proto_err (proto_err)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; up_req = 1'b0; blk_ack = '0;
        tick(); tick();
        chk("R1 req in reset", 32'(blk_req), 0);
        chk("R1 ack in reset", 32'(up_ack), 0);
        chk("R1 err in reset", 32'(proto_err), 0);
        rst_n = 1'b1;
        tick();
        chk("R1 req after reset", 32'(blk_req), 0);
        chk("R1 ack after reset", 32'(up_ack), 0);
    endtask

    task automatic t_idle();
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R2 idle no request", 32'(blk_req), 0);
        end
    endtask

    // drain: withdraw upstream, then drop acks in the given two steps
    task automatic drain(input logic [NB-1:0] mid);
        up_req = 1'b0; tick();
        chk("R5 requests drop together", 32'(blk_req), 0);
        chk("R5 ack held", 32'(up_ack), 1);
        blk_ack = mid; tick();
        chk("R6 ack held while child high", 32'(up_ack), 1);
        blk_ack = '0; tick();
        chk("R6 ack falls", 32'(up_ack), 0);
    endtask

    task automatic t_full_run();
        up_req = 1'b1; tick();
        chk("R2 block 0 starts", 32'(blk_req), 32'b001);
        tick();
        chk("R3 no early hop", 32'(blk_req), 32'b001);
        blk_ack = 3'b001; tick();
        chk("R3 block 1 starts", 32'(blk_req), 32'b011);
        blk_ack = 3'b011; tick();
        chk("R3 block 2 starts", 32'(blk_req), 32'b111);
        chk("R4 no early up ack", 32'(up_ack), 0);
        blk_ack = 3'b111; tick();
        chk("R4 up ack rises", 32'(up_ack), 1);
        chk("R4 requests held", 32'(blk_req), 32'b111);
        tick();
        chk("R4 requests still held", 32'(blk_req), 32'b111);
        chk("R8 no error on clean run", 32'(proto_err), 0);
        drain(3'b101);
        chk("R8 no error on clean drain", 32'(proto_err), 0);
    endtask

    task automatic t_stale();
        blk_ack = 3'b001; up_req = 1'b1; tick();
        chk("R7 start blocked by stale ack", 32'(blk_req), 0);
        chk("R8 rise with req low", 32'(proto_err), 1);
        tick();
        chk("R7 start still blocked", 32'(blk_req), 0);
        chk("R8 pulse lasts one cycle", 32'(proto_err), 0);
        blk_ack = 3'b000; tick();
        chk("R7 start after ack fell", 32'(blk_req), 32'b001);
        blk_ack = 3'b011; tick();
        chk("R7 hop blocked by stale ack", 32'(blk_req), 32'b001);
        tick();
        chk("R7 hop still blocked", 32'(blk_req), 32'b001);
        blk_ack = 3'b001; tick();
        chk("R7 hop after ack fell", 32'(blk_req), 32'b011);
        blk_ack = 3'b011; tick();
        blk_ack = 3'b111; tick();
        chk("R4 up ack after stale case", 32'(up_ack), 1);
        drain(3'b010);
    endtask

    task automatic t_fall_error();
        up_req = 1'b1; tick();
        blk_ack = 3'b001; tick();
        chk("R3 block 1 starts", 32'(blk_req), 32'b011);
        chk("R8 legal rise quiet", 32'(proto_err), 0);
        blk_ack = 3'b000; tick();
        chk("R8 fall with req high", 32'(proto_err), 1);
        blk_ack = 3'b010; tick();
        chk("R8 pulse ends", 32'(proto_err), 0);
        chk("R3 hop on ack 1", 32'(blk_req), 32'b111);
        blk_ack = 3'b110; tick();
        chk("R4 up ack rises", 32'(up_ack), 1);
        drain(3'b100);
    endtask

    task automatic t_mid_reset();
        up_req = 1'b1; tick();
        blk_ack = 3'b001; tick();
        rst_n = 1'b0; blk_ack = '0; up_req = 1'b0; tick();
        chk("R1 mid-run reset clears requests", 32'(blk_req), 0);
        chk("R1 mid-run reset clears ack", 32'(up_ack), 0);
        rst_n = 1'b1; tick();
        up_req = 1'b1; tick();
        chk("R2 restart after reset", 32'(blk_req), 32'b001);
        blk_ack = 3'b001; tick();
        blk_ack = 3'b011; tick();
        blk_ack = 3'b111; tick();
        chk("R4 up ack after restart", 32'(up_ack), 1);
        drain(3'b011);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_idle();
        t_full_run();
        t_stale();
        t_fall_error();
        t_mid_reset();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule